// File: doc/BRIEF.md
# Threshold Match Counter for Conversion Results

This block watches the stream of conversion results as they are written into the converter's data registers. It holds a small set of compare units. Each unit is set up by one 32-bit configuration write. It picks one channel and tests each result from that channel against a 12-bit unsigned threshold. It then counts how many results in a row meet the test. When the run reaches the programmed count plus one, the unit raises a sticky flag. Software clears the flag by writing a 1 to it. A single interrupt line is high while any flag is set and the interrupt of that flag is enabled.

Unit 0 can also run in window mode. In window mode, a result counts for unit 0 only when it meets unit 0's test and unit 1's test at the same time. Unit 1 keeps working on its own while this happens. The results themselves are produced elsewhere. They reach this block as a one-cycle strobe that carries the channel number and the 12-bit value.

Top module: `adc_result_compare`

## Requirements
- R1: A write on `cfg_we[u]` loads unit u's settings from `cfg_wdata`. The field layout is: bit 0 compare enable, bit 1 interrupt enable, bit 2 condition, bits 7:3 channel, bits 11:8 match count N, bit 15 window (unit 0 only), bits 27:16 threshold. The write also resets that unit's run counter to 0. A result that arrives in the same cycle as the write is not counted for that unit.
- R2: A unit only evaluates results whose channel equals its channel field, and only while its enable bit is 1. Any other result leaves its counter and its flag unchanged.
- R3: With condition 0, a result meets the test when it is less than the threshold. With condition 1, it meets the test when it is greater than or equal to the threshold. Both compares are unsigned on 12 bits.
- R4: The flag sets in the cycle after the (N+1)th meeting result in a row. The counter then restarts from 0, so N = 0 flags on every meeting result.
- R5: An evaluated result that fails the test resets the unit's counter to 0.
- R6: Writing 1 to `flag_clr[u]` clears flag u in the next cycle. If a new flag event happens in the same cycle, the flag stays set.
- R7: `cmp_irq` is high exactly while some flag is 1 and that unit's interrupt enable is 1. A configuration write does not clear the flag.
- R8: With the window bit set, a result counts for unit 0 only if it meets both unit 0's test and unit 1's test (unit 1's threshold and condition). Unit 1's enable and channel do not matter for this.
- R9: All five channel bits are compared. This means codes 28 and 29 (the internal floating-detect and band-gap channels) select just like codes 0 to 15.
- R10: After the synchronous reset, all flags are 0, `cmp_irq` is 0, and every unit is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_vld | input | 1 | One-cycle strobe: a result is being written |
| res_chan | input | 5 | Channel code of the result |
| res_data | input | 12 | Unsigned result value |
| cfg_we | input | N_UNITS | Per-unit configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| flag_clr | input | N_UNITS | Write-1-to-clear for each flag |
| cmp_flag | output | N_UNITS | Sticky flag for each unit |
| cmp_irq | output | 1 | Combined interrupt request |

## Verification
The bench tests results exactly at the threshold and one below it. A design that swaps the strict and non-strict compare flags one result too early or too late. The bench breaks a run with a failing result, sends results on other channels, and rewrites the configuration in the middle of a count. A counter that saturates, or that counts foreign channels, flags early. The bench also clears a flag in the same cycle as a new event, which catches a design that gives the clear priority. Window mode is driven with a result that passes unit 0 but fails unit 1. A design that ignores the peer unit's test then sets the flag too soon.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;

    localparam int RES_W = 12;
    localparam int CH_W  = 5;
    localparam int MC_W  = 4;
    localparam int CNT_W = MC_W + 1;
    localparam int CFG_W = 32;

    typedef struct packed {
        logic [RES_W-1:0] thresh;
        logic             window;
        logic [MC_W-1:0]  need;
        logic [CH_W-1:0]  chan;
        logic             ge_mode;
        logic             irq_en;
        logic             enable;
    } cmp_cfg_t;

    function automatic logic meets(input logic ge_mode,
                                   input logic [RES_W-1:0] thresh,
                                   input logic [RES_W-1:0] data);
        return ge_mode ? (data >= thresh) : (data < thresh);
    endfunction

endpackage

// File: rtl/adc_cmp_cond.sv
module adc_cmp_cond
    import adc_cmp_pkg::*;
(
    input  logic             ge_mode_i,
    input  logic [RES_W-1:0] thresh_i,
    input  logic [RES_W-1:0] data_i,
    output logic             ok_o
);
    always_comb ok_o = meets(ge_mode_i, thresh_i, data_i);
endmodule

// File: rtl/adc_cmp_unit.sv
module adc_cmp_unit
    import adc_cmp_pkg::*;
#(
    parameter bit HAS_WINDOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_vld_i,
    input  logic [CH_W-1:0]  res_chan_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             flag_clr_i,
    input  logic             self_ok_i,
    input  logic             peer_ok_i,
    output logic [RES_W-1:0] thresh_o,
    output logic             ge_mode_o,
    output logic             irq_en_o,
    output logic             flag_o
);
    cmp_cfg_t          cfg_q, cfg_d;
    logic [CNT_W-1:0]  cnt_q, cnt_inc, goal;
    logic              flag_q, sel_hit, met, reached, set_evt;
    logic              unused_rsvd;

    assign unused_rsvd = ^{cfg_wdata_i[31:28], cfg_wdata_i[14:12]};

    always_comb begin
        cfg_d.enable  = cfg_wdata_i[0];
        cfg_d.irq_en  = cfg_wdata_i[1];
        cfg_d.ge_mode = cfg_wdata_i[2];
        cfg_d.chan    = cfg_wdata_i[7:3];
        cfg_d.need    = cfg_wdata_i[11:8];
        cfg_d.window  = HAS_WINDOW ? cfg_wdata_i[15] : 1'b0;
        cfg_d.thresh  = cfg_wdata_i[27:16];
    end

    always_comb begin
        sel_hit = res_vld_i && cfg_q.enable && (res_chan_i == cfg_q.chan);
        met     = (HAS_WINDOW && cfg_q.window) ? (self_ok_i && peer_ok_i) : self_ok_i;
        cnt_inc = cnt_q + CNT_W'(1);
        goal    = CNT_W'(cfg_q.need) + CNT_W'(1);
        reached = sel_hit && met && (cnt_inc == goal);
        set_evt = reached && !cfg_we_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (cfg_we_i) begin
                cfg_q <= cfg_d;
                cnt_q <= '0;
            end else if (sel_hit) begin
                cnt_q <= (met && !reached) ? cnt_inc : '0;
            end
            if (set_evt)         flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
        end
    end

    assign thresh_o  = cfg_q.thresh;
    assign ge_mode_o = cfg_q.ge_mode;
    assign irq_en_o  = cfg_q.irq_en;
    assign flag_o    = flag_q;

    assert_cnt_below_goal_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(cfg_q.need));

    assert_write_zeroes_count_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_we_i |=> (cnt_q == '0));

    assert_flag_needs_result_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> ($past(res_vld_i) && $past(cfg_q.enable)));

    assert_clear_without_event_R6: assert property (@(posedge clk) disable iff (rst)
        (flag_clr_i && !res_vld_i) |=> !flag_o);
endmodule

// File: rtl/adc_result_compare.sv
module adc_result_compare
    import adc_cmp_pkg::*;
#(
    parameter int N_UNITS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               res_vld,
    input  logic [CH_W-1:0]    res_chan,
    input  logic [RES_W-1:0]   res_data,
    input  logic [N_UNITS-1:0] cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [N_UNITS-1:0] flag_clr,
    output logic [N_UNITS-1:0] cmp_flag,
    output logic               cmp_irq
);
    localparam int PEER = (N_UNITS > 1) ? 1 : 0;

    logic [RES_W-1:0]   thresh [N_UNITS];
    logic [N_UNITS-1:0] ge_mode, irq_en, ok;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        adc_cmp_cond cond_i (
            .ge_mode_i (ge_mode[u]),
            .thresh_i  (thresh[u]),
            .data_i    (res_data),
            .ok_o      (ok[u])
        );
        adc_cmp_unit #(.HAS_WINDOW(u == 0 && N_UNITS > 1)) unit_i (
            .clk         (clk),
            .rst         (rst),
            .res_vld_i   (res_vld),
            .res_chan_i  (res_chan),
            .cfg_we_i    (cfg_we[u]),
            .cfg_wdata_i (cfg_wdata),
            .flag_clr_i  (flag_clr[u]),
            .self_ok_i   (ok[u]),
            .peer_ok_i   (ok[PEER]),
            .thresh_o    (thresh[u]),
            .ge_mode_o   (ge_mode[u]),
            .irq_en_o    (irq_en[u]),
            .flag_o      (cmp_flag[u])
        );
    end

    assign cmp_irq = |(cmp_flag & irq_en);

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
        cmp_irq |-> (cmp_flag != '0));

    assert_flags_clear_after_reset_R10: assert property (@(posedge clk)
        rst |=> (cmp_flag == '0));
endmodule

// File: tb/adc_result_compare_tb_top.sv
`timescale 1ns/1ps
module adc_result_compare_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_vld = 1'b0;
    logic [4:0]  res_chan = '0;
    logic [11:0] res_data = '0;
    logic [1:0]  cfg_we = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  flag_clr = '0;
    logic [1:0]  cmp_flag;
    logic        cmp_irq;

    int n_checks = 0;
    int n_fail = 0;
    string phase = "R10";
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    adc_result_compare dut_i (
        .clk(clk), .rst(rst), .res_vld(res_vld), .res_chan(res_chan),
        .res_data(res_data), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .flag_clr(flag_clr), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
    );

    // behavioural reference
    int m_en[2], m_ie[2], m_ge[2], m_ch[2], m_need[2], m_win[2], m_thr[2], m_cnt[2];
    bit m_flg[2];
    bit okv[2];
    bit m_met, m_set;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            for (int u = 0; u < 2; u++) begin
                m_en[u] = 0; m_ie[u] = 0; m_ge[u] = 0; m_ch[u] = 0;
                m_need[u] = 0; m_win[u] = 0; m_thr[u] = 0; m_cnt[u] = 0; m_flg[u] = 0;
            end
        end else begin
            for (int u = 0; u < 2; u++)
                okv[u] = m_ge[u] ? (int'(res_data) >= m_thr[u]) : (int'(res_data) < m_thr[u]);
            for (int u = 0; u < 2; u++) begin
                m_set = 0;
                if (cfg_we[u]) begin
                    m_en[u] = cfg_wdata[0]; m_ie[u] = cfg_wdata[1]; m_ge[u] = cfg_wdata[2];
                    m_ch[u] = cfg_wdata[7:3]; m_need[u] = cfg_wdata[11:8];
                    m_win[u] = (u == 0) ? int'(cfg_wdata[15]) : 0;
                    m_thr[u] = cfg_wdata[27:16]; m_cnt[u] = 0;
                end else if (res_vld && m_en[u] != 0 && m_ch[u] == int'(res_chan)) begin
                    m_met = (m_win[u] != 0) ? (okv[0] && okv[1]) : okv[u];
                    if (m_met) begin
                        m_cnt[u]++;
                        if (m_cnt[u] == m_need[u] + 1) begin m_set = 1; m_cnt[u] = 0; end
                    end else m_cnt[u] = 0;
                end
                if (m_set) m_flg[u] = 1;
                else if (flag_clr[u]) m_flg[u] = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            n_checks++;
            if (cmp_flag !== {m_flg[1], m_flg[0]} ||
                cmp_irq !== ((m_flg[0] && m_ie[0] != 0) || (m_flg[1] && m_ie[1] != 0))) begin
                n_fail++;
                $display("FAIL %s model: flag=%b irq=%b expected flag=%b irq=%b", phase,
                         cmp_flag, cmp_irq, {m_flg[1], m_flg[0]},
                         (m_flg[0] && m_ie[0] != 0) || (m_flg[1] && m_ie[1] != 0));
            end
        end
    end

    function automatic logic [31:0] mk(int en, int ie, int ge, int ch, int need, int win, int thr);
        logic [31:0] w = '0;
        w[0] = en[0]; w[1] = ie[0]; w[2] = ge[0]; w[7:3] = ch[4:0];
        w[11:8] = need[3:0]; w[15] = win[0]; w[27:16] = thr[11:0];
        return w;
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wcfg(int u, logic [31:0] w);
        @(negedge clk); cfg_we[u] = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_we = '0;
    endtask

    task automatic send(int ch, int d);
        @(negedge clk); res_vld = 1'b1; res_chan = ch[4:0]; res_data = d[11:0];
        @(negedge clk); res_vld = 1'b0;
    endtask

    task automatic clr(logic [1:0] m);
        @(negedge clk); flag_clr = m;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic clr_send(logic [1:0] m, int ch, int d);
        @(negedge clk); flag_clr = m; res_vld = 1'b1; res_chan = ch[4:0]; res_data = d[11:0];
        @(negedge clk); flag_clr = '0; res_vld = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 flags", cmp_flag, 2'b00);
        check("R10 irq", {1'b0, cmp_irq}, 2'b00);

        phase = "R4";
        wcfg(0, mk(1, 0, 0, 3, 2, 0, 'h800));
        send(3, 'h100); check("R4 first", cmp_flag, 2'b00);
        send(5, 'h100); check("R2 other channel", cmp_flag, 2'b00);
        send(3, 'h7FF); check("R4 second", cmp_flag, 2'b00);
        send(3, 'h000); check("R4 third sets", cmp_flag, 2'b01);
        clr(2'b01);     check("R6 clear", cmp_flag, 2'b00);

        phase = "R5";
        wcfg(0, mk(1, 0, 0, 3, 1, 0, 'h800));
        send(3, 10); send(3, 'h900); send(3, 10);
        check("R5 run broken", cmp_flag, 2'b00);
        send(3, 10); check("R5 run complete", cmp_flag, 2'b01);
        clr(2'b01);

        phase = "R3";
        wcfg(0, mk(1, 0, 1, 4, 0, 0, 'h400));
        send(4, 'h3FF); check("R3 below ge", cmp_flag, 2'b00);
        send(4, 'h400); check("R3 equal ge", cmp_flag, 2'b01);
        clr(2'b01);
        wcfg(0, mk(1, 0, 0, 4, 0, 0, 'h400));
        send(4, 'h400); check("R3 equal lt", cmp_flag, 2'b00);
        send(4, 'h3FF); check("R3 below lt", cmp_flag, 2'b01);
        clr(2'b01);

        phase = "R6";
        wcfg(0, mk(1, 0, 1, 4, 1, 0, 'h400));
        send(4, 'h500);
        clr_send(2'b01, 4, 'h500); check("R6 set wins", cmp_flag, 2'b01);
        clr(2'b01); check("R6 cleared", cmp_flag, 2'b00);

        phase = "R7";
        wcfg(1, mk(1, 1, 0, 7, 0, 0, 'h010));
        send(7, 5); check("R7 irq on", {cmp_flag[1], cmp_irq}, 2'b11);
        wcfg(1, mk(0, 0, 0, 7, 0, 0, 'h010));
        check("R7 irq masked flag kept", {cmp_flag[1], cmp_irq}, 2'b10);
        clr(2'b10);

        phase = "R2";
        wcfg(0, mk(0, 1, 0, 2, 0, 0, 'hFFF));
        send(2, 1); check("R2 disabled", cmp_flag, 2'b00);

        phase = "R1";
        wcfg(0, mk(1, 0, 0, 2, 1, 0, 'h800));
        send(2, 1);
        wcfg(0, mk(1, 0, 0, 2, 1, 0, 'h800));
        send(2, 1); check("R1 rewrite restarts", cmp_flag, 2'b00);
        send(2, 1); check("R1 count after rewrite", cmp_flag, 2'b01);
        clr(2'b01);

        phase = "R8";
        wcfg(1, mk(0, 0, 0, 9, 0, 0, 'h200));
        wcfg(0, mk(1, 0, 1, 6, 1, 1, 'h100));
        send(6, 'h150); send(6, 'h250); send(6, 'h150);
        check("R8 peer fail resets", cmp_flag, 2'b00);
        send(6, 'h150); check("R8 window sets", cmp_flag, 2'b01);
        clr(2'b01);

        phase = "R9";
        wcfg(0, mk(1, 0, 0, 29, 0, 0, 'hFFF));
        send(28, 1); check("R9 code 28 not 29", cmp_flag, 2'b00);
        send(29, 1); check("R9 code 29", cmp_flag, 2'b01);
        clr(2'b01);
        wcfg(1, mk(1, 0, 1, 28, 0, 0, 0));
        send(12, 0); check("R9 code 12 not 28", cmp_flag, 2'b00);
        send(28, 0); check("R9 code 28", cmp_flag, 2'b10);
        clr(2'b10);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule